// File: doc/BRIEF.md
# PHY Reset and Strap Latch Sequencer

This block decides when the registers of a PHY-style management block are held in reset, and when the strap pins are sampled into their configuration latches. Three sources can ask for a reset. The first is loss of the power-good indication, which acts as an asynchronous reset of the whole block. The second is an external active-high reset pin, which is synchronized and qualified by pulse width. The third is a one-cycle software write strobe, standing for a write of one to the self-clearing reset bit of the control register. All timing is counted in strobes of a one-microsecond tick input.

Each reset runs through the same phases. First comes a hold phase with the internal reset asserted. Then the reset is released and a short delay runs, after which the straps are latched. Only after a software reset does a settling phase follow, during which management access stays blocked. The block also drives the two speed indicator outputs. It forces their defaults while the power-up reset holds, and at all other times it passes through the speed selected by the datapath.

Top module: `phy_rst_seq`

## Requirements
- R1: The reset pin passes through two synchronizing flops. The pin is ignored (`core_rst` stays 0 and `mgmt_rdy` stays 1) unless its synchronized level stays high across at least PULSE_MIN_US+1 consecutive tick strobes, where PULSE_MIN_US defaults to 1.
- R2: A qualified pin pulse asserts `core_rst` and keeps it asserted for as long as the pin stays high. Once the synchronized pin falls, `core_rst` releases on the (RST_HOLD_US+1)th tick strobe, where RST_HOLD_US defaults to 10.
- R3: While `pwr_ok` is low, `core_rst` is 1 at once, `strap_q` is 0 and `mgmt_rdy` is 0. After `pwr_ok` rises, `core_rst` stays 1 until the (PWR_HOLD_US+1)th tick strobe, where PWR_HOLD_US defaults to 500.
- R4: `strap_q` takes the value of `strap_pins` on the (STRAP_DLY_US+1)th tick strobe after `core_rst` falls, where STRAP_DLY_US defaults to 2. The strap pin values at any other time have no effect, and `strap_q` holds its value until the next capture.
- R5: A one-cycle `sw_rst_wr` strobe starts a reset: from the next cycle `core_rst` is 1 and `sw_rst_bit` reads 1. `sw_rst_bit` stays 1 through the hold and strap-delay phases and clears in the cycle the straps are latched.
- R6: `mgmt_rdy` is 0 while a reset or strap delay is in progress. After a software reset it stays 0 until the (SETTLE_US+1)th tick strobe after the strap capture, where SETTLE_US defaults to 500. After a pin reset or a power-up reset it rises in the strap capture cycle.
- R7: A new pin or software request in any phase sends the sequence back to the start of the hold phase with its count restarted. Requests are not queued.
- R8: While the power-up hold is in progress, `spd10_led` is 1 and `spd100_led` is 0, whatever `spd_sel_100` is. At all other times, including pin and software resets, `spd100_led` equals `spd_sel_100` and `spd10_led` is its inverse.
- R9: A qualified pin request clears a pending software reset status, so `sw_rst_bit` reads 0 and no settling phase follows. A software write in the same cycle as a pin request takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pwr_ok | input | 1 | Power-good, low forces asynchronous reset |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| rst_pin | input | 1 | Asynchronous active-high reset pin |
| strap_pins | input | STRAP_W | Strap pin levels |
| sw_rst_wr | input | 1 | Software reset write strobe |
| spd_sel_100 | input | 1 | Speed in use by the datapath, 1 = 100 Mb/s |
| core_rst | output | 1 | Internal reset returning registers to defaults |
| strap_q | output | STRAP_W | Latched strap values |
| sw_rst_bit | output | 1 | Self-clearing software reset read-back |
| spd10_led | output | 1 | 10 Mb/s speed indicator |
| spd100_led | output | 1 | 100 Mb/s speed indicator |
| mgmt_rdy | output | 1 | Management access allowed |

## Verification
The assertions check on every cycle that a qualified pin request or software write forces the reset in the following cycle, and that the reset always releases on a tick strobe. They also check that a qualified pin level was already high in the cycle before, that the strap latch changes only on the tick that ends the strap delay, and that the status bit rises only after a software write. The exact hold, strap and settling lengths can only be shown by the bench scenarios. The same holds for which strap value is captured when the pins change around the capture tick, for a short pin pulse being ignored at every tick alignment, and for the hold count restarting on a request.

// File: rtl/phy_rst_seq.sv
module phy_rst_seq #(
  parameter int STRAP_W      = 5,
  parameter int PULSE_MIN_US = 1,
  parameter int PWR_HOLD_US  = 500,
  parameter int RST_HOLD_US  = 10,
  parameter int STRAP_DLY_US = 2,
  parameter int SETTLE_US    = 500
) (
  input  logic               clk,
  input  logic               pwr_ok,
  input  logic               us_tick,
  input  logic               rst_pin,
  input  logic [STRAP_W-1:0] strap_pins,
  input  logic               sw_rst_wr,
  input  logic               spd_sel_100,
  output logic               core_rst,
  output logic [STRAP_W-1:0] strap_q,
  output logic               sw_rst_bit,
  output logic               spd10_led,
  output logic               spd100_led,
  output logic               mgmt_rdy
);

  localparam int QUAL_TICKS = PULSE_MIN_US + 1;
  localparam int QW = $clog2(QUAL_TICKS + 1);
  localparam int M_A = (PWR_HOLD_US > RST_HOLD_US) ? PWR_HOLD_US : RST_HOLD_US;
  localparam int M_B = (STRAP_DLY_US > SETTLE_US) ? STRAP_DLY_US : SETTLE_US;
  localparam int MAX_LIM = (M_A > M_B) ? M_A : M_B;
  localparam int CW = $clog2(MAX_LIM + 1);

  typedef enum logic [1:0] {ST_HOLD, ST_STRAP, ST_SETTLE, ST_RUN} st_t;

  logic          pin_meta, pin_sync;
  logic [QW-1:0] pin_cnt;
  logic          hw_req, any_req;
  st_t           st;
  logic [CW-1:0] cnt, lim;
  logic          lim_hit;
  logic          pwr_phase, sw_phase;

  assign hw_req  = pin_sync && (pin_cnt == QW'(QUAL_TICKS));
  assign any_req = hw_req || sw_rst_wr;

  always_comb begin
    case (st)
      ST_HOLD:   lim = pwr_phase ? CW'(PWR_HOLD_US) : CW'(RST_HOLD_US);
      ST_STRAP:  lim = CW'(STRAP_DLY_US);
      ST_SETTLE: lim = CW'(SETTLE_US);
      default:   lim = '0;
    endcase
  end

  assign lim_hit = us_tick && (st != ST_RUN) && (cnt == lim);

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) begin
      pin_meta  <= 1'b0;
      pin_sync  <= 1'b0;
      pin_cnt   <= '0;
      st        <= ST_HOLD;
      cnt       <= '0;
      pwr_phase <= 1'b1;
      sw_phase  <= 1'b0;
      strap_q   <= '0;
    end else begin
      pin_meta <= rst_pin;
      pin_sync <= pin_meta;
      if (!pin_sync)
        pin_cnt <= '0;
      else if (us_tick && pin_cnt != QW'(QUAL_TICKS))
        pin_cnt <= pin_cnt + QW'(1);

      if (sw_rst_wr)   sw_phase <= 1'b1;
      else if (hw_req) sw_phase <= 1'b0;

      if (any_req) begin
        st  <= ST_HOLD;
        cnt <= '0;
      end else if (lim_hit) begin
        cnt <= '0;
        case (st)
          ST_HOLD: begin
            st        <= ST_STRAP;
            pwr_phase <= 1'b0;
          end
          ST_STRAP: begin
            strap_q <= strap_pins;
            st      <= sw_phase ? ST_SETTLE : ST_RUN;
          end
          default: st <= ST_RUN;
        endcase
      end else if (us_tick && st != ST_RUN) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign core_rst   = (st == ST_HOLD);
  assign mgmt_rdy   = (st == ST_RUN);
  assign sw_rst_bit = sw_phase && (st == ST_HOLD || st == ST_STRAP);
  assign spd10_led  = (core_rst && pwr_phase) ? 1'b1 : !spd_sel_100;
  assign spd100_led = (core_rst && pwr_phase) ? 1'b0 : spd_sel_100;

  p_qual_prev_r1: assert property (@(posedge clk) disable iff (!pwr_ok)
    hw_req |-> $past(pin_sync));

  p_release_on_tick_r3: assert property (@(posedge clk) disable iff (!pwr_ok)
    $fell(core_rst) |-> $past(us_tick));

  p_strap_only_capture_r4: assert property (@(posedge clk) disable iff (!pwr_ok)
    !$stable(strap_q) |-> $past(st == ST_STRAP && us_tick));

  p_swbit_from_write_r5: assert property (@(posedge clk) disable iff (!pwr_ok)
    $rose(sw_rst_bit) |-> $past(sw_rst_wr));

  p_rdy_on_tick_r6: assert property (@(posedge clk) disable iff (!pwr_ok)
    $rose(mgmt_rdy) |-> $past(us_tick));

  p_req_forces_rst_r7: assert property (@(posedge clk) disable iff (!pwr_ok)
    any_req |=> (core_rst && !mgmt_rdy));

endmodule

// File: tb/phy_rst_seq_bench.sv
module phy_rst_seq_bench;
  localparam int SW = 5, PMIN = 1, PHOLD = 500, RHOLD = 10, SDLY = 2, SETL = 500;

  logic clk, pwr_ok, us_tick, rst_pin, sw_rst_wr, spd_sel_100;
  logic [SW-1:0] strap_pins, strap_q;
  logic core_rst, sw_rst_bit, spd10_led, spd100_led, mgmt_rdy;
  int total = 0, bad = 0, div = 0;
  bit done = 0;

  localparam logic [SW:0] VEC [4] = '{6'b1_10110, 6'b0_01001, 6'b1_11111, 6'b0_00000};

  phy_rst_seq #(.STRAP_W(SW), .PULSE_MIN_US(PMIN), .PWR_HOLD_US(PHOLD),
    .RST_HOLD_US(RHOLD), .STRAP_DLY_US(SDLY), .SETTLE_US(SETL)) u_phy_rst_seq (
    .clk(clk), .pwr_ok(pwr_ok), .us_tick(us_tick), .rst_pin(rst_pin),
    .strap_pins(strap_pins), .sw_rst_wr(sw_rst_wr), .spd_sel_100(spd_sel_100),
    .core_rst(core_rst), .strap_q(strap_q), .sw_rst_bit(sw_rst_bit),
    .spd10_led(spd10_led), .spd100_led(spd100_led), .mgmt_rdy(mgmt_rdy));

  initial clk = 0;
  always #5 clk = ~clk;

  initial begin
    us_tick = 0;
    forever begin
      @(negedge clk);
      div = (div + 1) % 4;
      us_tick = (div == 0);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      do @(posedge clk); while (!us_tick);
    end
    @(negedge clk);
  endtask

  task automatic sw_pulse();
    @(negedge clk); sw_rst_wr = 1;
    @(negedge clk); sw_rst_wr = 0;
  endtask

  task automatic wait_release(output int n);
    n = 0;
    while (core_rst && n < 1000) begin
      @(posedge clk);
      if (us_tick) n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    pwr_ok = 1; rst_pin = 0; sw_rst_wr = 0; spd_sel_100 = 1; strap_pins = 5'h0A;
    #1 pwr_ok = 0;
    repeat (3) @(negedge clk);
    chk("R3 reset core_rst", core_rst, 1);
    chk("R3 reset mgmt_rdy", mgmt_rdy, 0);
    chk("R3 reset strap_q", strap_q, 0);
    chk("R8 pwr spd10", spd10_led, 1);
    chk("R8 pwr spd100", spd100_led, 0);
    pwr_ok = 1;
    ticks(PHOLD);
    chk("R3 hold not done", core_rst, 1);
    chk("R8 spd10 during hold", spd10_led, 1);
    ticks(1);
    chk("R3 hold released", core_rst, 0);
    chk("R8 spd100 follows sel", spd100_led, 1);
    ticks(SDLY);
    chk("R4 not yet latched", strap_q, 0);
    chk("R6 not ready in strap delay", mgmt_rdy, 0);
    strap_pins = 5'h15;
    ticks(1);
    chk("R4 power-up strap", strap_q, 5'h15);
    chk("R6 ready after power-up", mgmt_rdy, 1);

    foreach (VEC[i]) begin
      spd_sel_100 = VEC[i][SW];
      strap_pins = ~VEC[i][SW-1:0];
      sw_pulse();
      chk("R5 core_rst after write", core_rst, 1);
      chk("R5 sw bit set", sw_rst_bit, 1);
      ticks(RHOLD);
      chk("R5 hold not done", core_rst, 1);
      ticks(1);
      chk("R5 hold released", core_rst, 0);
      chk("R8 speed follows sel", spd100_led, int'(VEC[i][SW]));
      ticks(SDLY);
      chk("R5 sw bit in strap delay", sw_rst_bit, 1);
      strap_pins = VEC[i][SW-1:0];
      ticks(1);
      chk("R4 strap latched", strap_q, int'(VEC[i][SW-1:0]));
      chk("R5 sw bit cleared", sw_rst_bit, 0);
      chk("R6 settling", mgmt_rdy, 0);
      strap_pins = ~VEC[i][SW-1:0];
      ticks(SETL);
      chk("R6 still settling", mgmt_rdy, 0);
      ticks(1);
      chk("R6 ready after settle", mgmt_rdy, 1);
      chk("R4 strap holds", strap_q, int'(VEC[i][SW-1:0]));
    end

    sw_pulse();
    ticks(5);
    sw_pulse();
    ticks(RHOLD);
    chk("R7 restart in hold", core_rst, 1);
    ticks(1);
    chk("R7 release after restart", core_rst, 0);
    ticks(SDLY + 1 + 100);
    chk("R6 in settle", mgmt_rdy, 0);
    sw_pulse();
    chk("R7 restart from settle", core_rst, 1);
    ticks(RHOLD + 1 + SDLY + 1 + SETL + 1);
    chk("R7 full sequence after restart", mgmt_rdy, 1);

    for (int off = 0; off < 4; off++) begin
      repeat (off + 1) @(negedge clk);
      rst_pin = 1;
      repeat (3) @(negedge clk);
      rst_pin = 0;
      repeat (20) @(negedge clk);
      chk("R1 short pulse ignored", core_rst, 0);
      chk("R1 short pulse ready kept", mgmt_rdy, 1);
    end

    rst_pin = 1;
    repeat (20) @(negedge clk);
    chk("R2 long pulse resets", core_rst, 1);
    repeat (100) @(negedge clk);
    chk("R2 held while pin high", core_rst, 1);
    rst_pin = 0;
    wait_release(n);
    chk("R2 release min", int'(n >= RHOLD + 1), 1);
    chk("R2 release max", int'(n <= RHOLD + 2), 1);
    ticks(SDLY + 1);
    chk("R6 ready after pin reset", mgmt_rdy, 1);

    sw_pulse();
    chk("R9 sw bit before pin", sw_rst_bit, 1);
    rst_pin = 1;
    repeat (20) @(negedge clk);
    chk("R9 pin clears sw bit", sw_rst_bit, 0);
    rst_pin = 0;
    wait_release(n);
    ticks(SDLY + 1);
    chk("R9 no settle after pin", mgmt_rdy, 1);

    @(negedge clk); pwr_ok = 0;
    @(negedge clk);
    chk("R3 power loss core_rst", core_rst, 1);
    chk("R3 power loss strap", strap_q, 0);
    chk("R8 power loss spd10", spd10_led, 1);
    pwr_ok = 1;
    ticks(PHOLD);
    chk("R3 second hold", core_rst, 1);
    ticks(1);
    chk("R3 second release", core_rst, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule